// File: doc/BRIEF.md
# Parallel Data Capture Interface

This block takes bytes from an 8-bit parallel source, such as a camera sensor or a data converter, on the source's own capture clock. Each byte is accepted only when the data-enable inputs mark that edge as valid. Accepted bytes are packed four to a 32-bit word, moved into the system clock domain through a small Gray-pointer asynchronous FIFO, and offered on a ready/valid port that a DMA channel can drain without processor help.

Three control inputs set up the capture: a capture enable, a qualifier select and a half-rate option. The qualifier select chooses whether both enables or only the first must be high. The half-rate option keeps only every second accepted sample, which suits chrominance-only acquisition. If a finished word finds the FIFO full, the word is dropped and a sticky overrun flag rises in the system domain until software clears it.

Top module: `pcap_top`

## Requirements
- R1: After reset, `m_valid` and `ovr` are both 0.
- R2: With `cfg_de_sel`=0, a byte is accepted at a rising `cap_clk` edge only when `cap_de0` and `cap_de1` are both 1; bytes with either enable low are skipped.
- R3: With `cfg_de_sel`=1, a byte is accepted whenever `cap_de0` is 1, whatever the value of `cap_de1`; it is skipped when `cap_de0` is 0.
- R4: Four kept bytes form one word; the first kept byte sits in bits [7:0], the second in [15:8], the third in [23:16] and the fourth in [31:24].
- R5: With `cfg_half`=1, the first, third, fifth and later odd-numbered accepted bytes are kept and the even-numbered ones are discarded.
- R6: Clearing `cfg_en` resets the half-rate phase, so the first accepted byte after enabling is always kept.
- R7: Clearing `cfg_en` discards a partly filled word; packing restarts at bits [7:0] after enabling.
- R8: Words leave on `m_data` in capture order, one per cycle where `m_valid` and `m_ready` are both 1; while `m_valid` is 1 and `m_ready` is 0, `m_valid` stays 1 and `m_data` holds its value.
- R9: A word completed while the FIFO holds DEPTH words is dropped, and `ovr` becomes 1; `ovr` stays 1 until a cycle with `ovr_clr`=1, after which it reads 0 when no new drop has occurred.
- R10: While `cfg_en` is 0, no byte is accepted and no word is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| cfg_en | input | 1 | Capture enable |
| cfg_de_sel | input | 1 | 0: both data enables qualify; 1: only `cap_de0` qualifies |
| cfg_half | input | 1 | Keep every second accepted byte |
| cap_clk | input | 1 | Capture clock from the source |
| cap_data | input | DW | Parallel data, sampled on rising `cap_clk` |
| cap_de0 | input | 1 | First data enable |
| cap_de1 | input | 1 | Second data enable |
| m_data | output | 32 | Packed word to the DMA channel |
| m_valid | output | 1 | Word available |
| m_ready | input | 1 | Consumer takes the word this cycle |
| ovr | output | 1 | Sticky overrun flag |
| ovr_clr | input | 1 | Clears the overrun flag |

## Verification
The bench builds the block with its defaults: a four-word FIFO (address width 2) and 8-bit data, with a 10 ns system clock against a 14 ns capture clock. Four entries let the bench fill the FIFO with the consumer stalled and push a fifth word into a known drop, so the overrun path and the stall-hold of the output are reached with a handful of bytes. The unrelated clock periods make the pointer synchronizers see many phase offsets while ordered words stream out.

// File: rtl/pcap_pkg.sv
package pcap_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 32;

  typedef struct packed {
    logic en;
    logic de_sel;
    logic half;
  } pcap_cfg_t;
endpackage

// File: rtl/pcap_sync.sv
module pcap_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1_q;
  logic [W-1:0] s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;
endmodule

// File: rtl/pcap_packer.sv
module pcap_packer #(
  parameter int unsigned DW = 8,
  parameter int unsigned WW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          de_sel,
  input  logic          half,
  input  logic [DW-1:0] din,
  input  logic          de0,
  input  logic          de1,
  input  logic          full,
  output logic          push,
  output logic [WW-1:0] wdata,
  output logic          drop_tog
);
  localparam int unsigned LANES = WW / DW;
  localparam int unsigned IW    = $clog2(LANES);

  logic [IW-1:0] idx_q, idx_n;
  logic          tog_q, tog_n;
  logic [WW-1:0] word_q, word_n;
  logic          drop_q, drop_n;
  logic          acc, keep, last;

  always_comb begin
    acc  = en && (de_sel ? de0 : (de0 && de1));
    keep = acc && (!half || !tog_q);
    last = keep && (idx_q == IW'(LANES - 1));

    tog_n  = !en ? 1'b0 : (acc ? ~tog_q : tog_q);
    idx_n  = !en ? '0 : (keep ? IW'(idx_q + 1'b1) : idx_q);
    drop_n = drop_q ^ (last && full);
    word_n = word_q;
    for (int l = 0; l < LANES; l++) begin
      if (keep && (idx_q == IW'(l))) word_n[l*DW +: DW] = din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      tog_q  <= 1'b0;
      word_q <= '0;
      drop_q <= 1'b0;
    end else begin
      idx_q  <= idx_n;
      tog_q  <= tog_n;
      word_q <= word_n;
      drop_q <= drop_n;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    if (l == LANES - 1) begin : g_top
      assign wdata[l*DW +: DW] = din;
    end else begin : g_low
      assign wdata[l*DW +: DW] = word_q[l*DW +: DW];
    end
  end

  assign push     = last && !full;
  assign drop_tog = drop_q;
endmodule

// File: rtl/pcap_afifo.sv
module pcap_afifo #(
  parameter int unsigned W  = 32,
  parameter int unsigned AW = 2
) (
  input  logic         wclk,
  input  logic         wrst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  output logic         full,
  input  logic         rclk,
  input  logic         rrst_n,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty
);
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned PW    = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wbin_q, wbin_n, wgray_q, rgray_wq;
  logic [PW-1:0] rbin_q, rbin_n, rgray_q, wgray_rq;

  pcap_sync #(.W(PW)) u_r2w (.clk(wclk), .rst_n(wrst_n), .d(rgray_q), .q(rgray_wq));
  pcap_sync #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rrst_n), .d(wgray_q), .q(wgray_rq));

  always_comb begin
    full   = (wgray_q == (rgray_wq ^ {2'b11, {(PW-2){1'b0}}}));
    empty  = (rgray_q == wgray_rq);
    wbin_n = (push && !full) ? PW'(wbin_q + 1'b1) : wbin_q;
    rbin_n = (pop && !empty) ? PW'(rbin_q + 1'b1) : rbin_q;
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else begin
      wbin_q  <= wbin_n;
      wgray_q <= wbin_n ^ (wbin_n >> 1);
    end
  end

  always_ff @(posedge wclk) begin
    if (push && !full) mem[wbin_q[AW-1:0]] <= wdata;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else begin
      rbin_q  <= rbin_n;
      rgray_q <= rbin_n ^ (rbin_n >> 1);
    end
  end

  assign rdata = mem[rbin_q[AW-1:0]];
endmodule

// File: rtl/pcap_top.sv
module pcap_top
  import pcap_pkg::*;
#(
  parameter int unsigned DW = BYTE_W,
  parameter int unsigned AW = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_en,
  input  logic              cfg_de_sel,
  input  logic              cfg_half,
  input  logic              cap_clk,
  input  logic [DW-1:0]     cap_data,
  input  logic              cap_de0,
  input  logic              cap_de1,
  output logic [WORD_W-1:0] m_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic              ovr,
  input  logic              ovr_clr
);
  logic        sys_rst_n, cap_rst_n;
  pcap_cfg_t   cfg_in, cfg_cap;
  logic        push, fifo_full, fifo_empty, drop_tog;
  logic [WORD_W-1:0] wdata;
  logic        drop_s, drop_d_q, ovr_q, ovr_n;

  pcap_sync #(.W(1)) u_rs_sys (.clk(clk),     .rst_n(rst_n), .d(1'b1), .q(sys_rst_n));
  pcap_sync #(.W(1)) u_rs_cap (.clk(cap_clk), .rst_n(rst_n), .d(1'b1), .q(cap_rst_n));

  assign cfg_in = '{en: cfg_en, de_sel: cfg_de_sel, half: cfg_half};
  pcap_sync #(.W($bits(pcap_cfg_t))) u_cfg (
    .clk(cap_clk), .rst_n(cap_rst_n), .d(cfg_in), .q(cfg_cap)
  );

  pcap_packer #(.DW(DW), .WW(WORD_W)) u_pack (
    .clk(cap_clk), .rst_n(cap_rst_n), .en(cfg_cap.en), .de_sel(cfg_cap.de_sel),
    .half(cfg_cap.half), .din(cap_data), .de0(cap_de0), .de1(cap_de1),
    .full(fifo_full), .push(push), .wdata(wdata), .drop_tog(drop_tog)
  );

  pcap_afifo #(.W(WORD_W), .AW(AW)) u_fifo (
    .wclk(cap_clk), .wrst_n(cap_rst_n), .push(push), .wdata(wdata), .full(fifo_full),
    .rclk(clk), .rrst_n(sys_rst_n), .pop(m_ready), .rdata(m_data), .empty(fifo_empty)
  );

  pcap_sync #(.W(1)) u_drop (.clk(clk), .rst_n(sys_rst_n), .d(drop_tog), .q(drop_s));

  always_comb begin
    ovr_n = (ovr_q && !ovr_clr) || (drop_s != drop_d_q);
  end

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      drop_d_q <= 1'b0;
      ovr_q    <= 1'b0;
    end else begin
      drop_d_q <= drop_s;
      ovr_q    <= ovr_n;
    end
  end

  assign m_valid = !fifo_empty;
  assign ovr     = ovr_q;
endmodule

// File: rtl/pcap_chk.sv
module pcap_chk (
  input logic        clk,
  input logic        sys_rst_n,
  input logic        cap_clk,
  input logic        cap_rst_n,
  input logic [31:0] m_data,
  input logic        m_valid,
  input logic        m_ready,
  input logic        ovr,
  input logic        ovr_clr,
  input logic        drop_tog,
  input logic        fifo_full
);
  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data))); // R8

  AST_DATA_KNOWN: assert property (@(posedge clk) disable iff (!sys_rst_n)
    m_valid |-> !$isunknown(m_data)); // R8

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!sys_rst_n)
    (ovr && !ovr_clr) |=> ovr); // R9

  AST_OVR_FALL_BY_CLEAR: assert property (@(posedge clk) disable iff (!sys_rst_n)
    $fell(ovr) |-> $past(ovr_clr)); // R9

  AST_DROP_ONLY_WHEN_FULL: assert property (@(posedge cap_clk) disable iff (!cap_rst_n)
    (drop_tog != $past(drop_tog)) |-> $past(fifo_full)); // R9
endmodule

bind pcap_top pcap_chk u_chk (
  .clk(clk), .sys_rst_n(sys_rst_n), .cap_clk(cap_clk), .cap_rst_n(cap_rst_n),
  .m_data(m_data), .m_valid(m_valid), .m_ready(m_ready), .ovr(ovr),
  .ovr_clr(ovr_clr), .drop_tog(drop_tog), .fifo_full(fifo_full)
);

// File: tb/sim_pcap_top.sv
module sim_pcap_top;
  localparam int CLK_PERIOD = 10;
  localparam int CAP_PERIOD = 14;
  localparam int AW    = 2;
  localparam int DEPTH = 1 << AW;

  logic        clk = 1'b0, cap_clk = 1'b0, rst_n = 1'b0;
  logic        cfg_en = 1'b0, cfg_de_sel = 1'b0, cfg_half = 1'b0;
  logic [7:0]  cap_data = '0;
  logic        cap_de0 = 1'b0, cap_de1 = 1'b0;
  logic [31:0] m_data;
  logic        m_valid, ovr;
  logic        m_ready = 1'b1, ovr_clr = 1'b0;

  int total = 0, bad = 0;
  bit done = 0, mon_on = 0;
  string cur_req = "R4";
  logic [31:0] expq[$];

  bit m_en = 0, m_sel = 0, m_half = 0, m_tog = 0, rdy_on = 1;
  int m_idx = 0;
  logic [31:0] m_word = '0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always #(CAP_PERIOD/2) cap_clk = ~cap_clk;

  pcap_top #(.DW(8), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_de_sel(cfg_de_sel),
    .cfg_half(cfg_half), .cap_clk(cap_clk), .cap_data(cap_data),
    .cap_de0(cap_de0), .cap_de1(cap_de1), .m_data(m_data), .m_valid(m_valid),
    .m_ready(m_ready), .ovr(ovr), .ovr_clr(ovr_clr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic set_cfg(input bit en, input bit sel, input bit half);
    @(negedge cap_clk);
    cap_de0 = 0; cap_de1 = 0;
    cfg_en = en; cfg_de_sel = sel; cfg_half = half;
    m_en = en; m_sel = sel; m_half = half;
    if (!en) begin m_tog = 0; m_idx = 0; end
    repeat (6) @(negedge cap_clk);
  endtask

  task automatic cap_byte(input logic [7:0] d, input bit d0, input bit d1);
    bit acc, keep;
    @(negedge cap_clk);
    cap_data = d; cap_de0 = d0; cap_de1 = d1;
    acc  = m_en && (m_sel ? d0 : (d0 && d1));
    keep = acc && (!m_half || !m_tog);
    if (acc && m_half) m_tog = ~m_tog;
    if (keep) begin
      m_word[m_idx*8 +: 8] = d;
      m_idx++;
      if (m_idx == 4) begin
        m_idx = 0;
        if (!(!rdy_on && expq.size() >= DEPTH)) expq.push_back(m_word);
      end
    end
  endtask

  task automatic cap_idle();
    @(negedge cap_clk);
    cap_de0 = 0; cap_de1 = 0;
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 3000 && expq.size() != 0; i++) @(negedge clk);
    chk(req, 32'(expq.size()), 32'd0);
    repeat (10) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (mon_on && m_valid === 1'b1 && m_ready) begin
      if (expq.size() == 0) begin
        total++; bad++;
        $display("FAIL R8 actual=%h expected=no word", m_data);
      end else begin
        chk(cur_req, m_data, expq.pop_front());
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    chk("R1 m_valid", 32'(m_valid), 32'd0);
    chk("R1 ovr", 32'(ovr), 32'd0);
    mon_on = 1;

    // R2 / R4: both enables required
    cur_req = "R2/R4";
    set_cfg(1, 0, 0);
    cap_byte(8'h11, 1, 1); cap_byte(8'h99, 1, 0); cap_byte(8'h22, 1, 1);
    cap_byte(8'h98, 0, 1); cap_byte(8'h33, 1, 1); cap_byte(8'h97, 0, 0);
    cap_byte(8'h44, 1, 1);
    for (int i = 0; i < 8; i++) cap_byte(8'(8'h50 + i), 1, 1);
    cap_idle();
    drain("R2/R4");

    // R3: only the first enable qualifies
    cur_req = "R3";
    set_cfg(0, 1, 0);
    set_cfg(1, 1, 0);
    cap_byte(8'hA1, 1, 0); cap_byte(8'h5A, 0, 1); cap_byte(8'hA2, 1, 1);
    cap_byte(8'hA3, 1, 0); cap_byte(8'h5B, 0, 0); cap_byte(8'hA4, 1, 0);
    cap_idle();
    drain("R3");

    // R5: half-rate keeps odd-numbered accepted bytes
    cur_req = "R5";
    set_cfg(0, 0, 1);
    set_cfg(1, 0, 1);
    for (int i = 0; i < 8; i++) cap_byte(8'(8'hC0 + i), 1, 1);
    cap_idle();
    drain("R5");

    // R6 / R7: disable clears phase and partial word
    cur_req = "R6/R7";
    cap_byte(8'hD0, 1, 1); cap_byte(8'hD1, 1, 1); cap_byte(8'hD2, 1, 1);
    set_cfg(0, 0, 1);
    set_cfg(1, 0, 1);
    for (int i = 0; i < 8; i++) cap_byte(8'(8'hE0 + i), 1, 1);
    cap_idle();
    drain("R6/R7");

    // R10: disabled capture produces nothing
    cur_req = "R10";
    set_cfg(0, 0, 0);
    for (int i = 0; i < 8; i++) cap_byte(8'(8'h70 + i), 1, 1);
    cap_idle();
    repeat (40) @(negedge clk);
    chk("R10 m_valid", 32'(m_valid), 32'd0);

    // R9 / R8: stall, overflow, hold, clear, drain
    cur_req = "R9/R8";
    set_cfg(1, 0, 0);
    @(posedge clk); #2; m_ready = 0; rdy_on = 0;
    for (int w = 0; w < DEPTH + 1; w++)
      for (int b = 0; b < 4; b++) cap_byte(8'(w * 16 + b + 1), 1, 1);
    cap_idle();
    repeat (20) @(negedge clk);
    chk("R9 ovr set", 32'(ovr), 32'd1);
    chk("R8 m_valid held", 32'(m_valid), 32'd1);
    chk("R8 head word", m_data, expq[0]);
    @(posedge clk); #2; ovr_clr = 1;
    @(posedge clk); #2; ovr_clr = 0;
    @(negedge clk);
    chk("R9 ovr cleared", 32'(ovr), 32'd0);
    chk("R9 words kept", 32'(expq.size()), 32'(DEPTH));
    @(posedge clk); #2; m_ready = 1; rdy_on = 1;
    drain("R9/R8");
    chk("R8 m_valid idle", 32'(m_valid), 32'd0);
    chk("R9 ovr stays low", 32'(ovr), 32'd0);

    finish_run();
  end
endmodule